// File: doc/BRIEF.md
# Multicast Shared-Buffer Address-Copy Controller

This block is the control core of a small shared-buffer cell switch with `N_PORTS` outputs. Each arriving cell is written once into a common cell store at an address taken from a pool of unused addresses. The cell may target several outputs. Its address, not its payload, is copied into the address queue of every output whose destination bit is set. A per-address copy counter is loaded with the number of destinations. The counter drops by one for each copy that an output reads. When it reaches zero, the address goes back to the pool.

Each output shows the payload at the head of its address queue, using a valid/ready handshake. Several outputs may read the same cell in one cycle. The counter takes all of those decrements at once and releases the address a single time. A cell is refused, and a one-cycle drop flag is raised, in three cases: no address is available, the destination bitmap is empty, or a targeted queue is already full. A refused cell changes no state.

Admission is a small decision machine, evaluated every cycle, with three states:
- `ADM_IDLE`: no cell is offered.
- `ADM_STORE`: the cell is accepted. It takes an address, writes the store, pushes the queues and loads the counter.
- `ADM_DROP`: the cell is refused and `in_drop` is raised.

The transitions are decided fresh each cycle from `in_valid`, the bitmap, the queue fill levels and address availability:
- idle→store
- idle→drop
- store→drop
- drop→store

Top module: `mcsw_ctrl`

## Requirements
- R1: After reset all `out_valid` bits are low. The address pool holds all `DEPTH` addresses, so `DEPTH` cells can be accepted before any read.
- R2: A cell occupies exactly one buffer address whatever its fan-out. With no reads, `DEPTH` broadcast cells (bitmap all ones) are accepted, and the next cell is dropped.
- R3: Every output whose destination bit (bit i = output i) was set on an accepted cell delivers that cell's payload once, in arrival order, on `out_data[i*DATA_W +: DATA_W]`.
- R4: An address is not reused while any copy of its cell is unread. With the pool empty and one copy pending, a new cell is dropped.
- R5: When several outputs read copies of the same cell in one cycle, its address returns to the pool exactly once.
- R6: A cell offered with an all-zero destination bitmap is dropped.
- R7: A cell is dropped if any targeted output queue holds `QDEPTH` entries at the start of the cycle. This applies even if that queue is read in the same cycle. Full queues that are not targeted do not block the cell.
- R8: If the pool is empty and an address is released in the same cycle, the released address is given straight to the offered cell, and the cell is accepted.
- R9: An output pops only on `out_valid && out_ready`. While ready is low, `out_valid` stays high and `out_data` is stable.
- R10: `in_drop` is high in the same cycle as a refused `in_valid`, and low otherwise. A dropped cell changes no queue, counter or pool state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A cell is offered this cycle |
| in_data | input | DATA_W | Payload of the offered cell |
| in_dest | input | N_PORTS | Destination bitmap, bit i selects output i |
| in_drop | output | 1 | Offered cell refused this cycle |
| out_valid | output | N_PORTS | Output i has a cell to deliver |
| out_ready | input | N_PORTS | Output i takes its head cell this cycle |
| out_data | output | N_PORTS*DATA_W | Head payload of each output, output i in slice i |

## Verification
The bench fills the store with broadcast cells to confirm that each cell uses one address. A design that stores one copy per destination would drop cells early. It drains cells that are read on all outputs in the same cycle, then refills the store. A design that releases such an address twice would accept a cell too many or corrupt payloads. A design that releases it not at all would drop cells forever.

Directed cases cover:
- an empty pool with one copy still pending, which an early release would wrongly accept;
- a same-cycle release into an empty pool, which a design without bypass would wrongly drop;
- a full targeted queue that is read in the same cycle;
- a zero bitmap.

Random traffic with random ready patterns then compares every delivered payload against a bench model of the queues.

// File: rtl/mcsw_pkg.sv
package mcsw_pkg;

    // admission outcome for the cell offered in the current cycle
    typedef enum logic [1:0] {
        ADM_IDLE  = 2'd0,
        ADM_STORE = 2'd1,
        ADM_DROP  = 2'd2
    } adm_e;

endpackage

// File: rtl/mcsw_free_pool.sv
// Pool of unused buffer addresses: one take and up to N_REL returns per cycle.
module mcsw_free_pool #(
    parameter int DEPTH = 8,
    parameter int N_REL = 4,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_REL-1:0]          rel_vld,
    input  logic [N_REL-1:0][AW-1:0]  rel_addr,
    input  logic                      take,
    output logic                      avail,
    output logic [AW-1:0]             grant_addr
);
    localparam int IW  = (N_REL > 1) ? $clog2(N_REL) : 1;
    localparam int CNW = AW + 1;

    logic [AW-1:0]  slot_q [DEPTH];
    logic [AW-1:0]  head_q, tail_q;
    logic [CNW-1:0] level_q;

    logic           empty, any_rel, found;
    logic [IW-1:0]  first_idx;
    logic [N_REL-1:0] push_m;
    logic [AW-1:0]  wr_pos [N_REL];
    logic [AW-1:0]  acc;
    logic [CNW-1:0] n_push;
    logic           pop;

    assign empty   = (level_q == '0);
    assign any_rel = |rel_vld;
    assign avail   = !empty || any_rel;
    assign pop     = take && !empty;

    always_comb begin
        first_idx = '0;
        found     = 1'b0;
        for (int i = 0; i < N_REL; i++) begin
            if (rel_vld[i] && !found) begin
                first_idx = IW'(i);
                found     = 1'b1;
            end
        end
    end

    assign grant_addr = empty ? rel_addr[first_idx] : slot_q[head_q];

    always_comb begin
        push_m = rel_vld;
        if (take && empty) push_m[first_idx] = 1'b0;   // bypassed, not stored
        acc    = tail_q;
        n_push = '0;
        for (int i = 0; i < N_REL; i++) begin
            wr_pos[i] = acc;
            if (push_m[i]) begin
                acc    = acc + 1'b1;
                n_push = n_push + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) slot_q[k] <= AW'(k);
            head_q  <= '0;
            tail_q  <= '0;
            level_q <= CNW'(DEPTH);
        end else begin
            for (int i = 0; i < N_REL; i++) begin
                if (push_m[i]) slot_q[wr_pos[i]] <= rel_addr[i];
            end
            if (pop) head_q <= head_q + 1'b1;
            tail_q  <= acc;
            level_q <= level_q + n_push - CNW'(pop);
        end
    end

    AST_FREE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= CNW'(DEPTH));                                  // R5
    AST_FREE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> avail);                                          // R8

endmodule

// File: rtl/mcsw_addr_q.sv
// Address queue of one output.
module mcsw_addr_q #(
    parameter int QDEPTH = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          pop,
    output logic          nonempty,
    output logic          full,
    output logic [AW-1:0] head_addr
);
    localparam int QW = $clog2(QDEPTH);

    logic [AW-1:0] ent_q [QDEPTH];
    logic [QW-1:0] rd_q, wr_q;
    logic [QW:0]   fill_q;

    assign nonempty  = (fill_q != '0);
    assign full      = (fill_q == (QW+1)'(QDEPTH));
    assign head_addr = ent_q[rd_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= '0;
            wr_q   <= '0;
            fill_q <= '0;
        end else begin
            if (push) begin
                ent_q[wr_q] <= push_addr;
                wr_q        <= wr_q + 1'b1;
            end
            if (pop) rd_q <= rd_q + 1'b1;
            fill_q <= fill_q + (QW+1)'(push) - (QW+1)'(pop);
        end
    end

    AST_Q_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);                                          // R7
    AST_Q_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> nonempty);                                        // R9

endmodule

// File: rtl/mcsw_copy_cnt.sv
// Remaining-copy counter per buffer address, with merged same-cycle decrements.
module mcsw_copy_cnt #(
    parameter int DEPTH = 8,
    parameter int N_DEC = 4,
    parameter int AW = 3,
    parameter int CW = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ld,
    input  logic [AW-1:0]             ld_addr,
    input  logic [CW-1:0]             ld_val,
    input  logic [N_DEC-1:0]          dec_vld,
    input  logic [N_DEC-1:0][AW-1:0]  dec_addr,
    output logic [N_DEC-1:0]          rel_vld
);
    logic [CW-1:0] cnt_q [DEPTH];
    logic [CW-1:0] cnt_d [DEPTH];
    logic [CW-1:0] tot   [DEPTH];
    logic [CW-1:0] same  [N_DEC];
    logic [N_DEC-1:0] lead;

    always_comb begin
        for (int a = 0; a < DEPTH; a++) begin
            tot[a] = '0;
            for (int i = 0; i < N_DEC; i++) begin
                if (dec_vld[i] && dec_addr[i] == AW'(a)) tot[a] = tot[a] + 1'b1;
            end
            cnt_d[a] = cnt_q[a] - tot[a];
            if (ld && ld_addr == AW'(a)) cnt_d[a] = ld_val;
        end
    end

    always_comb begin
        for (int i = 0; i < N_DEC; i++) begin
            same[i] = '0;
            lead[i] = 1'b1;
            for (int j = 0; j < N_DEC; j++) begin
                if (dec_vld[j] && dec_addr[j] == dec_addr[i]) begin
                    same[i] = same[i] + 1'b1;
                    if (j < i) lead[i] = 1'b0;
                end
            end
            rel_vld[i] = dec_vld[i] && lead[i] && (cnt_q[dec_addr[i]] == same[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) cnt_q[a] <= '0;
        end else begin
            for (int a = 0; a < DEPTH; a++) cnt_q[a] <= cnt_d[a];
        end
    end

    for (genvar g = 0; g < N_DEC; g++) begin : g_chk
        AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
            dec_vld[g] |-> (cnt_q[dec_addr[g]] >= same[g]));      // R4
    end

endmodule

// File: rtl/mcsw_ctrl.sv
// Shared-buffer multicast controller: single-copy storage, address fan-out.
module mcsw_ctrl #(
    parameter int N_PORTS = 4,
    parameter int DEPTH   = 8,
    parameter int QDEPTH  = 8,
    parameter int DATA_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [DATA_W-1:0]           in_data,
    input  logic [N_PORTS-1:0]          in_dest,
    output logic                        in_drop,
    output logic [N_PORTS-1:0]          out_valid,
    input  logic [N_PORTS-1:0]          out_ready,
    output logic [N_PORTS*DATA_W-1:0]   out_data
);
    import mcsw_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(N_PORTS + 1);

    logic [DATA_W-1:0]          cell_q [DEPTH];
    logic [N_PORTS-1:0]         q_full, q_pop;
    logic [N_PORTS-1:0][AW-1:0] q_head;
    logic [N_PORTS-1:0]         rel_vld;
    logic                       avail, take;
    logic [AW-1:0]              grant_addr;
    logic [CW-1:0]              fanout;
    adm_e                       adm;

    // admission decision
    always_comb begin
        if (!in_valid)
            adm = ADM_IDLE;
        else if (in_dest == '0 || (in_dest & q_full) != '0 || !avail)
            adm = ADM_DROP;
        else
            adm = ADM_STORE;
    end

    // admission outputs
    always_comb begin
        take    = 1'b0;
        in_drop = 1'b0;
        unique case (adm)
            ADM_IDLE:  ;
            ADM_STORE: take    = 1'b1;
            ADM_DROP:  in_drop = 1'b1;
            default:   ;
        endcase
    end

    always_comb begin
        fanout = '0;
        for (int i = 0; i < N_PORTS; i++) fanout = fanout + CW'(in_dest[i]);
    end

    assign q_pop = out_valid & out_ready;

    mcsw_free_pool #(.DEPTH(DEPTH), .N_REL(N_PORTS)) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .rel_vld    (rel_vld),
        .rel_addr   (q_head),
        .take       (take),
        .avail      (avail),
        .grant_addr (grant_addr)
    );

    mcsw_copy_cnt #(.DEPTH(DEPTH), .N_DEC(N_PORTS), .AW(AW), .CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (take),
        .ld_addr  (grant_addr),
        .ld_val   (fanout),
        .dec_vld  (q_pop),
        .dec_addr (q_head),
        .rel_vld  (rel_vld)
    );

    for (genvar g = 0; g < N_PORTS; g++) begin : g_out
        mcsw_addr_q #(.QDEPTH(QDEPTH), .AW(AW)) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (take && in_dest[g]),
            .push_addr (grant_addr),
            .pop       (q_pop[g]),
            .nonempty  (out_valid[g]),
            .full      (q_full[g]),
            .head_addr (q_head[g])
        );

        assign out_data[g*DATA_W +: DATA_W] = cell_q[q_head[g]];

        AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[g] && !out_ready[g]) |=>
                (out_valid[g] && $stable(out_data[g*DATA_W +: DATA_W])));  // R9
    end

    always_ff @(posedge clk) begin
        if (take) cell_q[grant_addr] <= in_data;
    end

    AST_DROP_ZERO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_dest == '0) |-> in_drop);                 // R6
    AST_DROP_NEEDS_CELL: assert property (@(posedge clk) disable iff (!rst_n)
        in_drop |-> in_valid);                                    // R10

endmodule

// File: tb/mcsw_ctrl_bench.sv
`timescale 1ns/1ps
module mcsw_ctrl_bench;
    localparam int NP = 4;
    localparam int DP = 8;
    localparam int QD = 8;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [NP-1:0] in_dest = '0;
    logic in_drop;
    logic [NP-1:0] out_valid;
    logic [NP-1:0] out_ready = '0;
    logic [NP*DW-1:0] out_data;

    always #4 clk = ~clk;

    mcsw_ctrl #(.N_PORTS(NP), .DEPTH(DP), .QDEPTH(QD), .DATA_W(DW)) u_mcsw_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_dest(in_dest), .in_drop(in_drop), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model
    int mq [NP][$];
    int rem [int];
    logic [DW-1:0] pay [int];
    int live = 0;
    int next_id = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [DW-1:0] d, input logic [NP-1:0] dst,
                        input logic [NP-1:0] rdy, input string tag);
        int relc;
        bit ok_q, acc;
        @(negedge clk);
        in_valid  = v;
        in_data   = d;
        in_dest   = dst;
        out_ready = rdy;
        #1;
        for (int i = 0; i < NP; i++) begin
            chk(out_valid[i] == (mq[i].size() > 0), tag, out_valid[i], mq[i].size() > 0);
            if (mq[i].size() > 0)
                chk(out_data[i*DW +: DW] == pay[mq[i][0]], "R3",
                    out_data[i*DW +: DW], pay[mq[i][0]]);
        end
        relc = 0;
        for (int i = 0; i < NP; i++) begin
            if (mq[i].size() > 0 && rdy[i]) begin
                rem[mq[i][0]] = rem[mq[i][0]] - 1;
                if (rem[mq[i][0]] == 0) relc++;
            end
        end
        ok_q = 1'b1;
        for (int i = 0; i < NP; i++) if (dst[i] && mq[i].size() >= QD) ok_q = 1'b0;
        acc = v && (dst != '0) && ok_q && (live < DP || relc > 0);
        chk(in_drop == (v && !acc), tag, in_drop, v && !acc);
        for (int i = 0; i < NP; i++) if (mq[i].size() > 0 && rdy[i]) void'(mq[i].pop_front());
        live = live - relc;
        if (acc) begin
            rem[next_id] = $countones(dst);
            pay[next_id] = d;
            for (int i = 0; i < NP; i++) if (dst[i]) mq[i].push_back(next_id);
            next_id++;
            live++;
        end
    endtask

    task automatic drain(input string tag);
        for (int k = 0; k < QD + 2; k++) step(1'b0, '0, '0, '1, tag);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        step(1'b0, '0, '0, '0, "R1");
        chk(out_valid == '0, "R1", out_valid, 0);
        // R2: broadcast cells take one address each
        for (int k = 0; k < DP; k++) step(1'b1, DW'(16'h100 + k), '1, '0, "R2");
        step(1'b1, 16'hdead, '1, '0, "R2");
        // R4: one copy pending keeps the address
        step(1'b0, '0, '0, 4'b0111, "R4");
        step(1'b1, 16'hbeef, 4'b0001, '0, "R4");
        // R8: same-cycle release bypassed into empty pool
        step(1'b1, 16'hcafe, 4'b0001, 4'b1000, "R8");
        // R5: simultaneous reads of one cell, then refill to capacity
        drain("R5");
        for (int k = 0; k < DP; k++) step(1'b1, DW'(16'h200 + k), 4'b1011, '0, "R5");
        step(1'b1, 16'h2ff, 4'b0100, '0, "R5");
        drain("R5");
        // R6: zero bitmap
        step(1'b1, 16'h0bad, '0, '0, "R6");
        step(1'b0, '0, '0, '0, "R10");
        // R7: full targeted queue read this cycle still blocks
        for (int k = 0; k < QD; k++) step(1'b1, DW'(16'h300 + k), 4'b0100, '0, "R7");
        step(1'b1, 16'h3aa, 4'b0110, 4'b0100, "R7");
        step(1'b1, 16'h3bb, 4'b0001, 4'b0100, "R7");
        drain("R7");
        // R9: hold with ready low
        step(1'b1, 16'h4444, 4'b0010, '0, "R9");
        for (int k = 0; k < 3; k++) step(1'b0, '0, '0, 4'b1101, "R9");
        drain("R9");
        // random traffic, R3 and R10
        for (int k = 0; k < 4000; k++) begin
            logic vv;
            vv = ($urandom % 4) != 0;
            step(vv, DW'($urandom), NP'($urandom), NP'($urandom), "R3");
        end
        drain("R10");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule